// File: doc/BRIEF.md
# RTC Interrupt Enable, Flag and Status Registers

This block is the interrupt section of a real-time-clock register file. Three event sources outside it (a periodic tap of the divider, an alarm match and the end of a calendar update) each send a one-cycle pulse. Every pulse latches a sticky flag. Each flag has its own enable bit in a control register. The active-low interrupt request is driven whenever some flag and its enable are both 1.

Software reaches the block through a simple register port. A single access strobe comes with a write qualifier, a two-bit address and a byte of write data. Read data is a combinational mux of the addressed register. The control register holds an update-hold bit, the three enables and four mode bits that are passed on to the calendar logic. The flag register gives the summary interrupt bit and the three flags. Reading it clears all of them. The status register reports that RAM and time are valid. The update-hold bit is also sent out, so that the calendar engine can stop advancing while software sets the time.

Top module: `rtc_irq_regs`

## Requirements
- R1: While rst_ni is low and after it rises, all flags and all three enables are 0, the whole control register reads 0x00 and irq_no is 1.
- R2: A pulse on periodic_evt_i, alarm_evt_i or update_evt_i sets its flag at the next clock edge. This happens whatever the enable bits hold. The flag register (address 1) shows the periodic flag on bit 6, the alarm flag on bit 5 and the update flag on bit 4, with bits 3..0 reading 0.
- R3: Bit 7 of the flag register, and the low level of irq_no, are present exactly when some flag is 1 together with its enable. Both are combinational from the stored bits. Setting an enable while its flag is already 1 therefore drives irq_no low in the cycle right after the write edge.
- R4: A read of address 1 (req_i=1, we_i=0) returns the flags as they stand in that cycle. At the closing edge it clears all flags, and irq_no returns to 1.
- R5: An event pulse that arrives in the same cycle as a flag-register read leaves its flag set after the clear.
- R6: A control write with bit 7 = 1 while the hold bit is 0 stores the update enable (bit 4) as 0, whatever the write data holds. A write with bit 7 = 1 while the hold bit is already 1 stores bit 4 as written.
- R7: The status register (address 2) always reads 0x80, which is the valid bit 7 set to 1. This holds during reset as well.
- R8: Writes to address 1 or address 2 change neither the flags nor the status value.
- R9: The control register (address 0) reads back the last byte written: bit 7 is the hold bit, bit 6 the periodic enable, bit 5 the alarm enable, bit 4 the update enable, and bits 3..0 are mode bits. update_hold_o follows bit 7 and mode_o follows bits 3..0. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| periodic_evt_i | input | 1 | One-cycle pulse from the divider tap |
| alarm_evt_i | input | 1 | One-cycle pulse on alarm match |
| update_evt_i | input | 1 | One-cycle pulse at end of an update |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address: 0 control, 1 flags, 2 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| irq_no | output | 1 | Active-low interrupt request |
| update_hold_o | output | 1 | Hold bit, stops calendar updates |
| mode_o | output | 4 | Control-register mode bits for the calendar logic |

## Verification
Read data and the summary bit are combinational. Any change in stored state therefore shows up on rdata_o and irq_no one edge after the stimulus that caused it, and an address change shows up in the same cycle. The bench drives inputs just after the falling edge. At the next falling edge it compares both outputs with a behavioural model, which has absorbed exactly one rising edge since the last comparison. The directed checks sample at the same point. They cover reset, enable-after-flag, read-clear, an event that collides with a read, and the hold-bit edge.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int NUM_EVT = 3;

  // event index, also bit order above EVT_LSB
  localparam int EV_UPD = 0;
  localparam int EV_ALM = 1;
  localparam int EV_PER = 2;

  localparam int TOP_BIT  = DATA_W - 1;
  localparam int EVT_LSB  = TOP_BIT - NUM_EVT;
  localparam int MODE_W   = EVT_LSB;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic ctrl_wr;
    logic flag_rd;
  } acc_t;
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
  import rtc_irq_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_t              acc_o
);
  always_comb begin
    acc_o.ctrl_wr = req_i &&  we_i && (addr_i == ADDR_CTRL);
    acc_o.flag_rd = req_i && !we_i && (addr_i == ADDR_FLAG);
  end
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_EVT-1:0] en_o,
  output logic               hold_o,
  output logic [MODE_W-1:0]  mode_o
);
  logic [NUM_EVT-1:0] en_q;
  logic               hold_q;
  logic [MODE_W-1:0]  mode_q;
  logic               hold_rise;

  assign hold_rise = wdata_i[TOP_BIT] && !hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      mode_q <= '0;
    end else if (wr_i) begin
      hold_q <= wdata_i[TOP_BIT];
      mode_q <= wdata_i[MODE_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_en
    logic nxt;
    // entering hold forces the update enable off
    if (i == EV_UPD) begin : g_upd
      assign nxt = wdata_i[EVT_LSB+i] && !hold_rise;
    end else begin : g_oth
      assign nxt = wdata_i[EVT_LSB+i];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q[i] <= 1'b0;
      else if (wr_i) en_q[i] <= nxt;
    end
  end

  assign en_o   = en_q;
  assign hold_o = hold_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_i,
  input  logic [NUM_EVT-1:0] en_i,
  output logic [NUM_EVT-1:0] flag_o,
  output logic               sum_o
);
  logic [NUM_EVT-1:0] flag_q;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    // set wins over clear-on-read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (evt_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i)    flag_q[i] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign sum_o  = |(flag_q & en_i);
endmodule

// File: rtl/rtc_rd_mux.sv
module rtc_rd_mux
  import rtc_irq_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               hold_i,
  input  logic [NUM_EVT-1:0] en_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [NUM_EVT-1:0] flag_i,
  input  logic               sum_i,
  output logic [DATA_W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {hold_i, en_i, mode_i};
      ADDR_FLAG: rdata_o = {sum_i, flag_i, {MODE_W{1'b0}}};
      ADDR_STAT: rdata_o[TOP_BIT] = 1'b1;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              periodic_evt_i,
  input  logic              alarm_evt_i,
  input  logic              update_evt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_no,
  output logic              update_hold_o,
  output logic [MODE_W-1:0] mode_o
);
  acc_t               acc;
  logic [NUM_EVT-1:0] evt;
  logic [NUM_EVT-1:0] en_w;
  logic [NUM_EVT-1:0] flag_w;
  logic               sum_w;

  always_comb begin
    evt         = '0;
    evt[EV_PER] = periodic_evt_i;
    evt[EV_ALM] = alarm_evt_i;
    evt[EV_UPD] = update_evt_i;
  end

  rtc_bus_decode u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .acc_o  (acc)
  );

  rtc_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (acc.ctrl_wr),
    .wdata_i (wdata_i),
    .en_o    (en_w),
    .hold_o  (update_hold_o),
    .mode_o  (mode_o)
  );

  rtc_flag_reg u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (acc.flag_rd),
    .en_i   (en_w),
    .flag_o (flag_w),
    .sum_o  (sum_w)
  );

  rtc_rd_mux u_mux (
    .addr_i  (addr_i),
    .hold_i  (update_hold_o),
    .en_i    (en_w),
    .mode_i  (mode_o),
    .flag_i  (flag_w),
    .sum_i   (sum_w),
    .rdata_o (rdata_o)
  );

  assign irq_no = ~sum_w;
endmodule

// File: rtl/rtc_irq_regs_chk.sv
module rtc_irq_regs_chk
  import rtc_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_no,
  input logic               update_hold_o,
  input logic [NUM_EVT-1:0] evt,
  input logic [NUM_EVT-1:0] en_w,
  input logic [NUM_EVT-1:0] flag_w
);
  logic flag_rd, ctrl_wr, ro_wr;
  assign flag_rd = req_i && !we_i && (addr_i == ADDR_FLAG);
  assign ctrl_wr = req_i &&  we_i && (addr_i == ADDR_CTRL);
  assign ro_wr   = req_i &&  we_i && (addr_i == ADDR_FLAG || addr_i == ADDR_STAT);

  assert_reset_idle_R1: assert property (@(posedge clk_i) !rst_ni |-> irq_no);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt[i] |=> flag_w[i]);
    assert_evt_beats_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt[i] && flag_rd) |=> flag_w[i]);
    assert_pair_drives_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_w[i] && en_w[i]) |-> !irq_no);
  end

  assert_sum_matches_pin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_FLAG) |-> (rdata_o[TOP_BIT] == !irq_no));

  assert_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd && evt == '0) |=> (flag_w == '0 && irq_no));

  assert_hold_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[TOP_BIT] && !update_hold_o) |=> !en_w[EV_UPD]);

  assert_ro_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ro_wr && evt == '0) |=> $stable(flag_w));

  always_comb begin
    if (addr_i == ADDR_STAT) begin
      assert_valid_bit_R7: assert (rdata_o == 8'h80);
    end
  end
endmodule

bind rtc_irq_regs rtc_irq_regs_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .irq_no        (irq_no),
  .update_hold_o (update_hold_o),
  .evt           (evt),
  .en_w          (en_w),
  .flag_w        (flag_w)
);

// File: tb/rtc_irq_regs_test.sv
module rtc_irq_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       pe = 1'b0, ae = 1'b0, ue = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;
  logic       irq_n, hold;
  logic [3:0] mode;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_fp, m_fa, m_fu, m_ep, m_ea, m_eu, m_hold, m_mode;

  always #2 clk = ~clk;

  rtc_irq_regs uut (
    .clk_i(clk), .rst_ni(rst_n),
    .periodic_evt_i(pe), .alarm_evt_i(ae), .update_evt_i(ue),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .irq_no(irq_n), .update_hold_o(hold), .mode_o(mode)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fp = 0; m_fa = 0; m_fu = 0; m_ep = 0; m_ea = 0; m_eu = 0;
      m_hold = 0; m_mode = 0;
    end else begin
      int rd, cw, was_hold;
      rd = (req && !we && addr == 2'd1);
      cw = (req && we && addr == 2'd0);
      m_fp = pe ? 1 : (rd ? 0 : m_fp);
      m_fa = ae ? 1 : (rd ? 0 : m_fa);
      m_fu = ue ? 1 : (rd ? 0 : m_fu);
      if (cw) begin
        was_hold = m_hold;
        m_hold = wd[7];
        m_ep = wd[6];
        m_ea = wd[5];
        m_eu = (wd[7] && !was_hold) ? 0 : int'(wd[4]);
        m_mode = wd[3:0];
      end
    end
  end

  function automatic int m_sum();
    return ((m_fp && m_ep) || (m_fa && m_ea) || (m_fu && m_eu)) ? 1 : 0;
  endfunction

  function automatic logic [7:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {m_hold[0], m_ep[0], m_ea[0], m_eu[0], m_mode[3:0]};
      2'd1: return {m_sum() != 0, m_fp[0], m_fa[0], m_fu[0], 4'h0};
      2'd2: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string req_tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req_tag, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    chk(irq_n == !m_sum(), "R3 irq_no", irq_n, !m_sum());
    chk(rdata == m_read(addr), (addr == 2'd2) ? "R7 status" :
        (addr == 2'd1) ? "R4 flags" : "R9 ctrl", rdata, m_read(addr));
    chk(hold == m_hold[0], "R9 hold_o", hold, m_hold);
  endtask

  task automatic step(bit p, bit a, bit u, bit r, bit w, logic [1:0] ad, logic [7:0] d);
    @(negedge clk);
    model_cmp();
    pe = p; ae = a; ue = u; req = r; we = w; addr = ad; wd = d;
  endtask

  task automatic peek(logic [1:0] ad, logic [7:0] exp, string tag);
    step(0, 0, 0, 0, 0, ad, 8'h00);
    #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(irq_n == 1'b1, "R1 irq in reset", irq_n, 1);
    addr = 2'd0; #1;
    chk(rdata == 8'h00, "R1 ctrl in reset", rdata, 8'h00);
    addr = 2'd2; #1;
    chk(rdata == 8'h80, "R7 status in reset", rdata, 8'h80);
    @(negedge clk) rst_n = 1'b1;

    // R2: flags set with enables off
    step(1, 0, 0, 0, 0, 2'd0, 8'h00);
    peek(2'd1, 8'h40, "R2 periodic flag");
    chk(irq_n == 1'b1, "R2 no irq without enable", irq_n, 1);
    step(0, 1, 1, 0, 0, 2'd0, 8'h00);
    peek(2'd1, 8'h70, "R2 alarm+update flags");

    // R3: enable after flag asserts at once
    step(0, 0, 0, 1, 1, 2'd0, 8'h20);
    step(0, 0, 0, 0, 0, 2'd1, 8'h00);
    #1;
    chk(irq_n == 1'b0, "R3 irq after enable", irq_n, 0);
    chk(rdata == 8'hF0, "R3 summary bit", rdata, 8'hF0);

    // R4: read returns then clears
    step(0, 0, 0, 1, 0, 2'd1, 8'h00);
    #1;
    chk(rdata == 8'hF0, "R4 read value", rdata, 8'hF0);
    peek(2'd1, 8'h00, "R4 cleared");
    chk(irq_n == 1'b1, "R4 irq released", irq_n, 1);

    // R8: writes to read-only registers
    step(1, 0, 0, 0, 0, 2'd0, 8'h00);
    step(0, 0, 0, 1, 1, 2'd1, 8'h00);
    step(0, 0, 0, 1, 1, 2'd2, 8'h00);
    peek(2'd1, 8'h40, "R8 flags after write");
    peek(2'd2, 8'h80, "R8 status after write");

    // R5: event colliding with read
    step(0, 0, 1, 1, 0, 2'd1, 8'h00);
    peek(2'd1, 8'h10, "R5 update survives read");

    // R6: entering hold drops update enable
    step(0, 0, 0, 1, 1, 2'd0, 8'h90);
    peek(2'd0, 8'h80, "R6 hold rise clears update enable");
    chk(hold == 1'b1, "R6 hold_o", hold, 1);
    chk(irq_n == 1'b1, "R6 irq off", irq_n, 1);
    step(0, 0, 0, 1, 1, 2'd0, 8'h90);
    peek(2'd0, 8'h90, "R6 hold already set keeps enable");
    chk(irq_n == 1'b0, "R6 irq from update", irq_n, 0);

    // R9: full readback, unused address
    step(0, 0, 0, 1, 1, 2'd0, 8'h6A);
    peek(2'd0, 8'h6A, "R9 ctrl readback");
    chk(mode == 4'hA, "R9 mode_o", mode, 4'hA);
    peek(2'd3, 8'h00, "R9 address 3");

    // R1: reset mid-run
    step(1, 1, 1, 0, 0, 2'd0, 8'h00);
    step(0, 0, 0, 0, 0, 2'd0, 8'h00);
    #1 rst_n = 1'b0;
    #1;
    chk(irq_n == 1'b1, "R1 irq after reset", irq_n, 1);
    chk(rdata == 8'h00, "R1 ctrl after reset", rdata, 8'h00);
    addr = 2'd1; #1;
    chk(rdata == 8'h00, "R1 flags after reset", rdata, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [7:0] v;
      v = 8'($urandom);
      step(($urandom % 5) == 0, ($urandom % 7) == 0, ($urandom % 6) == 0,
           ($urandom % 3) == 0, v[0], 2'($urandom), 8'($urandom));
    end
    step(0, 0, 0, 0, 0, 2'd1, 8'h00);
    step(0, 0, 0, 0, 0, 2'd0, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule